// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is one channel of a general-purpose timer. A free-running counter and its overflow strobe come from outside and are shared by all channels. The channel setting chooses one of three roles. It can capture the counter value when the external pin changes. It can change the pin when the counter reaches a programmed compare value. It can produce a PWM waveform by pairing toggle-on-overflow with a compare action.

Software writes the mode and edge/level fields, a toggle-on-overflow bit, a max-duty bit and the compare value. In buffered mode, a new compare value waits in a holding register and only becomes active at the next overflow. This keeps a running PWM period free of glitches. An event flag marks each capture or compare match and stays set until software clears it.

Top module: `tmr_chan`

## Requirements
- R1: After reset, or whenever the edge/level field is 00, `pin_oe` is 0. `pin_out` then settles, one clock after the setting, to 1 if mode bit 0 is 0 and to 0 if mode bit 0 is 1.
- R2: With mode 00, edge/level 01 captures on rising pin edges, 10 on falling edges and 11 on both. A pin level first sampled at rising clock edge k loads `cap_val`, at edge k+2, with the `cnt_val` present at that edge.
- R3: `cap_val` does not change outside capture mode, or on a pin edge that the edge/level field does not select.
- R4: With mode not 00 and edge/level not 00, `pin_oe` is 1. On a clock edge where `cnt_val` equals the active compare value, `pin_out` toggles for edge/level 01, goes to 0 for 10 and goes to 1 for 11.
- R5: With the toggle-on-overflow bit set, an output channel toggles `pin_out` on every clock edge that samples `cnt_ovf` high. In capture mode the bit changes nothing at the pins.
- R6: When overflow and compare match fall on the same edge with toggle-on-overflow set, only the overflow action is applied.
- R7: With toggle-on-overflow set, the max-duty bit takes effect only at the next overflow. From then on, `pin_out` holds the period-start level (0 for edge/level 11, 1 otherwise) and compare matches are ignored. The overflow after the bit is cleared also drives the period-start level, and normal compare action resumes after it.
- R8: A selected capture edge, or a compare match in an output mode, sets `evt_flag` one clock later. The flag stays set until a `flag_clr` pulse, and a new event in the same cycle as the clear wins.
- R9: With mode bit 1 set, a compare write goes to a holding register and becomes active at the next overflow edge. If the write lands on that overflow edge itself, it waits for the following overflow. With mode bit 1 clear, a write is active from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | Counter overflow strobe, one clock wide |
| cfg_we | input | 1 | Write strobe for the setting fields |
| cfg_mode | input | 2 | Mode field (bit 1: buffered, bit 0: output select/preset) |
| cfg_edge | input | 2 | Edge/level field |
| cfg_tov | input | 1 | Toggle-on-overflow bit |
| cfg_maxd | input | 1 | Max-duty bit |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value |
| flag_clr | input | 1 | Clears the event flag |
| pin_in | input | 1 | External channel pin, asynchronous |
| pin_out | output | 1 | Channel pin output level |
| pin_oe | output | 1 | 1 when the channel drives the pin, 0 when the port owns it |
| cap_val | output | CNT_W | Last captured counter value |
| evt_flag | output | 1 | Channel event flag |

## Verification
A wrong compare register shows up as a `pin_out` edge at the wrong counter value within one PWM period. A buffered value loaded too early or too late is exposed at the first overflow after the write. A wrong max-duty latch state shows as a missing or extra `pin_out` transition at the first compare point of the period that follows. A synchronizer that is one stage short or long shows in `cap_val` right after the edge, because the captured count is off by one.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

   typedef enum logic [1:0] {
      EL_NONE     = 2'b00,
      EL_RISE_TGL = 2'b01,
      EL_FALL_CLR = 2'b10,
      EL_BOTH_SET = 2'b11
   } edge_lvl_e;

   typedef struct packed {
      logic [1:0] mode;
      edge_lvl_e  el;
      logic       tov;
      logic       maxd;
   } chan_cfg_t;

   function automatic logic is_output(chan_cfg_t c);
      return (c.mode != 2'b00) && (c.el != EL_NONE);
   endfunction

   function automatic logic is_capture(chan_cfg_t c);
      return (c.mode == 2'b00) && (c.el != EL_NONE);
   endfunction

   function automatic logic start_level(edge_lvl_e el);
      return (el != EL_BOTH_SET);
   endfunction

   function automatic logic match_action(edge_lvl_e el, logic cur);
      logic r;
      case (el)
         EL_RISE_TGL: r = ~cur;
         EL_FALL_CLR: r = 1'b0;
         EL_BOTH_SET: r = 1'b1;
         default:     r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;
   logic              lvl;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= pin_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign lvl = chain[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs #(
   parameter int W          = 16,
   parameter bit HAS_BUFFER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         buf_mode,
   input  logic         ovf,
   output logic [W-1:0] cmp_act
);
   if (W < 2) begin : g_bad_w
      $error("tmr_cmp_regs: W must be at least 2");
   end

   if (HAS_BUFFER) begin : g_buffered
      logic [W-1:0] hold_q;
      logic         pend_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_q  <= '0;
            pend_q  <= 1'b0;
            cmp_act <= '0;
         end else if (buf_mode) begin
            if (ovf && pend_q) cmp_act <= hold_q;
            if (we) begin
               hold_q <= wdata;
               pend_q <= 1'b1;
            end else if (ovf) begin
               pend_q <= 1'b0;
            end
         end else begin
            pend_q <= 1'b0;
            if (we) cmp_act <= wdata;
         end
      end
   end else begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n)  cmp_act <= '0;
         else if (we) cmp_act <= wdata;
      end
   end
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl
   import tmr_chan_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  chan_cfg_t cfg,
   input  logic      ovf,
   input  logic      match,
   output logic      pin_q,
   output logic      maxd_eff
);
   logic out_mode;
   logic pin_d;
   logic maxd_d;

   assign out_mode = is_output(cfg);

   always_comb begin
      pin_d  = pin_q;
      maxd_d = maxd_eff;
      if (!out_mode) begin
         maxd_d = 1'b0;
      end else if (ovf) begin
         maxd_d = cfg.tov & cfg.maxd;
      end

      if (cfg.el == EL_NONE) begin
         pin_d = ~cfg.mode[0];
      end else if (!out_mode) begin
         pin_d = pin_q;
      end else if (ovf && cfg.tov) begin
         if (cfg.maxd || maxd_eff) pin_d = start_level(cfg.el);
         else                      pin_d = ~pin_q;
      end else if (maxd_eff) begin
         pin_d = pin_q;
      end else if (match) begin
         pin_d = match_action(cfg.el, pin_q);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q    <= 1'b1;
         maxd_eff <= 1'b0;
      end else begin
         pin_q    <= pin_d;
         maxd_eff <= maxd_d;
      end
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_BUFFER  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_ovf,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_edge,
   input  logic             cfg_tov,
   input  logic             cfg_maxd,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             flag_clr,
   input  logic             pin_in,
   output logic             pin_out,
   output logic             pin_oe,
   output logic [CNT_W-1:0] cap_val,
   output logic             evt_flag
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tmr_chan: CNT_W must be in 2..32");
   end

   chan_cfg_t        cfg_q;
   logic [CNT_W-1:0] cmp_act;
   logic             maxd_eff;
   logic             pin_rise;
   logic             pin_fall;
   logic             match;
   logic             cap_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '{mode: 2'b00, el: EL_NONE, tov: 1'b0, maxd: 1'b0};
      end else if (cfg_we) begin
         cfg_q <= '{mode: cfg_mode, el: edge_lvl_e'(cfg_edge),
                    tov: cfg_tov, maxd: cfg_maxd};
      end
   end

   tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_raw (pin_in),
      .rise    (pin_rise),
      .fall    (pin_fall)
   );

   tmr_cmp_regs #(.W(CNT_W), .HAS_BUFFER(HAS_BUFFER)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cmp_we),
      .wdata    (cmp_wdata),
      .buf_mode (cfg_q.mode[1]),
      .ovf      (cnt_ovf),
      .cmp_act  (cmp_act)
   );

   assign match = is_output(cfg_q) && (cnt_val == cmp_act);

   tmr_out_ctl u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q),
      .ovf      (cnt_ovf),
      .match    (match),
      .pin_q    (pin_out),
      .maxd_eff (maxd_eff)
   );

   always_comb begin
      cap_hit = 1'b0;
      if (is_capture(cfg_q)) begin
         case (cfg_q.el)
            EL_RISE_TGL: cap_hit = pin_rise;
            EL_FALL_CLR: cap_hit = pin_fall;
            EL_BOTH_SET: cap_hit = pin_rise | pin_fall;
            default:     cap_hit = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_val  <= '0;
         evt_flag <= 1'b0;
      end else begin
         if (cap_hit) cap_val <= cnt_val;
         if (cap_hit || match) evt_flag <= 1'b1;
         else if (flag_clr)    evt_flag <= 1'b0;
      end
   end

   assign pin_oe = is_output(cfg_q);
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
   import tmr_chan_pkg::*;
#(
   parameter int W          = 16,
   parameter bit HAS_BUFFER = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cnt_ovf,
   input logic [W-1:0] cnt_val,
   input logic         flag_clr,
   input chan_cfg_t    cfg_q,
   input logic [W-1:0] cmp_act,
   input logic         maxd_eff,
   input logic         pin_out,
   input logic [W-1:0] cap_val,
   input logic         evt_flag
);
   logic outm;
   logic capm;
   assign outm = is_output(cfg_q);
   assign capm = is_capture(cfg_q);

   // R1: with edge/level 00 the pin settles to the preset level
   a_r1_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.el == EL_NONE) |=> (pin_out == !$past(cfg_q.mode[0])));

   // R3: captured value holds outside capture mode
   a_r3_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capm |=> $stable(cap_val));

   // R6: overflow beats a coincident compare match
   a_r6_ovf_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (outm && cfg_q.tov && !cfg_q.maxd && !maxd_eff && cnt_ovf && (cnt_val == cmp_act))
      |=> (pin_out != $past(pin_out)));

   // R7: during max duty the pin only moves at overflow
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (outm && maxd_eff && !cnt_ovf) |=> $stable(pin_out));

   // R8: flag is sticky until cleared
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flag && !flag_clr) |=> evt_flag);

   if (HAS_BUFFER) begin : g_buf_chk
      // R9: buffered active compare changes only at overflow
      a_r9_buf_load: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q.mode[1] && !cnt_ovf) |=> $stable(cmp_act));
   end
endmodule

bind tmr_chan tmr_chan_chk #(.W(CNT_W), .HAS_BUFFER(HAS_BUFFER)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_ovf  (cnt_ovf),
   .cnt_val  (cnt_val),
   .flag_clr (flag_clr),
   .cfg_q    (cfg_q),
   .cmp_act  (cmp_act),
   .maxd_eff (maxd_eff),
   .pin_out  (pin_out),
   .cap_val  (cap_val),
   .evt_flag (evt_flag)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt_val = '0;
   logic         cnt_ovf = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_mode = 2'b00;
   logic [1:0]   cfg_edge = 2'b00;
   logic         cfg_tov = 1'b0;
   logic         cfg_maxd = 1'b0;
   logic         cmp_we = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic         flag_clr = 1'b0;
   logic         pin_in = 1'b0;
   logic         pin_out;
   logic         pin_oe;
   logic [W-1:0] cap_val;
   logic         evt_flag;

   int    per = 16;
   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   tmr_chan u0 (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
      .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_edge(cfg_edge),
      .cfg_tov(cfg_tov), .cfg_maxd(cfg_maxd), .cmp_we(cmp_we),
      .cmp_wdata(cmp_wdata), .flag_clr(flag_clr), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .cap_val(cap_val), .evt_flag(evt_flag)
   );

   // behavioural reference
   bit [1:0]   m_mode, m_el;
   bit         m_tov, m_maxd, m_meff, m_pin, m_flag, m_pend;
   bit [W-1:0] m_cap, m_act, m_buf;
   bit         hist[$];

   always @(posedge clk) begin
      bit outm, capm, rise, fall, capev, hit, np, nmeff;
      if (!rst_n) begin
         m_mode = 0; m_el = 0; m_tov = 0; m_maxd = 0; m_meff = 0;
         m_pin = 1; m_flag = 0; m_pend = 0; m_cap = 0; m_act = 0; m_buf = 0;
         hist = '{0, 0, 0};
      end else begin
         outm  = (m_mode != 0) && (m_el != 0);
         capm  = (m_mode == 0) && (m_el != 0);
         rise  = hist[1] && !hist[0];
         fall  = !hist[1] && hist[0];
         capev = capm && ((m_el == 1 && rise) || (m_el == 2 && fall) || (m_el == 3 && (rise || fall)));
         hit   = outm && (cnt_val == m_act);
         np    = m_pin;
         nmeff = !outm ? 0 : (cnt_ovf ? (m_tov && m_maxd) : m_meff);
         if (m_el == 0) np = !m_mode[0];
         else if (!outm) np = m_pin;
         else if (cnt_ovf && m_tov) np = (m_maxd || m_meff) ? (m_el != 3) : !m_pin;
         else if (m_meff) np = m_pin;
         else if (hit) np = (m_el == 1) ? !m_pin : (m_el == 3);
         m_pin  = np;
         m_meff = nmeff;
         if (capev) m_cap = cnt_val;
         if (capev || hit) m_flag = 1;
         else if (flag_clr) m_flag = 0;
         if (m_mode[1]) begin
            if (cnt_ovf && m_pend) m_act = m_buf;
            if (cmp_we) begin m_buf = cmp_wdata; m_pend = 1; end
            else if (cnt_ovf) m_pend = 0;
         end else begin
            m_pend = 0;
            if (cmp_we) m_act = cmp_wdata;
         end
         if (cfg_we) begin
            m_mode = cfg_mode; m_el = cfg_edge; m_tov = cfg_tov; m_maxd = cfg_maxd;
         end
         void'(hist.pop_front());
         hist.push_back(pin_in);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(pin_out == m_pin, cur_req, "pin_out", pin_out, m_pin);
      chk(pin_oe == ((m_mode != 0) && (m_el != 0)), cur_req, "pin_oe", pin_oe,
          (m_mode != 0) && (m_el != 0));
      chk(cap_val == m_cap, cur_req, "cap_val", cap_val, m_cap);
      chk(evt_flag == m_flag, cur_req, "evt_flag", evt_flag, m_flag);
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
      if (cnt_val == W'(per - 1)) cnt_val = '0;
      else cnt_val = cnt_val + 1'b1;
      cnt_ovf = (cnt_val == W'(per - 1));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wr_cfg(input bit [1:0] md, input bit [1:0] el, input bit tv, input bit mx);
      cfg_mode = md; cfg_edge = el; cfg_tov = tv; cfg_maxd = mx; cfg_we = 1'b1;
      cyc();
      cfg_we = 1'b0;
   endtask

   task automatic wr_cmp(input int v);
      cmp_wdata = W'(v); cmp_we = 1'b1;
      cyc();
      cmp_we = 1'b0;
   endtask

   task automatic clr_flag();
      flag_clr = 1'b1;
      cyc();
      flag_clr = 1'b0;
   endtask

   task automatic wait_cnt(input int v);
      for (int i = 0; i < 4 * per && cnt_val != W'(v); i++) cyc();
   endtask

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int x;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(pin_oe == 0, "R1", "reset pin_oe", pin_oe, 0);
      chk(pin_out == 1, "R1", "reset pin_out", pin_out, 1);
      chk(evt_flag == 0, "R1", "reset evt_flag", evt_flag, 0);
      chk(cap_val == 0, "R1", "reset cap_val", cap_val, 0);
      run(3);
      wr_cfg(2'b01, 2'b00, 0, 0);
      run(2);
      chk(pin_out == 0 && pin_oe == 0, "R1", "preset low", pin_out, 0);

      // R2 / R3 capture
      cur_req = "R2";
      wr_cfg(2'b00, 2'b01, 0, 0);
      run(2);
      x = cnt_val; pin_in = 1'b1;
      run(3);
      chk(cap_val == W'((x + 2) % per), "R2", "rise capture", cap_val, (x + 2) % per);
      chk(evt_flag == 1, "R8", "flag on capture", evt_flag, 1);
      run(4); pin_in = 1'b0; run(6);
      cur_req = "R3";
      chk(cap_val == W'((x + 2) % per), "R3", "falling ignored", cap_val, (x + 2) % per);
      cur_req = "R8";
      clr_flag(); run(2);
      chk(evt_flag == 0, "R8", "flag cleared", evt_flag, 0);
      cur_req = "R2";
      wr_cfg(2'b00, 2'b10, 0, 0);
      run(3); pin_in = 1'b1; run(7); pin_in = 1'b0; run(9);
      wr_cfg(2'b00, 2'b11, 1, 0);
      cur_req = "R5";
      for (int k = 0; k < 5; k++) begin pin_in = ~pin_in; run(3 + 2 * k); end
      chk(pin_oe == 0, "R5", "tov ignored in capture", pin_oe, 0);

      // R4 compare actions, unbuffered
      cur_req = "R4";
      pin_in = 1'b0;
      wr_cmp(5);
      wr_cfg(2'b01, 2'b01, 0, 0);
      run(3 * per);
      wait_cnt(5); run(1);
      chk(pin_oe == 1, "R4", "oe in output mode", pin_oe, 1);
      wr_cfg(2'b01, 2'b11, 0, 0);
      run(2 * per);
      chk(pin_out == 1, "R4", "set on compare", pin_out, 1);
      wr_cfg(2'b01, 2'b10, 0, 0);
      wr_cmp(9);
      run(2 * per);
      chk(pin_out == 0, "R4", "clear on compare", pin_out, 0);
      cur_req = "R3";
      pin_in = 1'b1; run(5); pin_in = 1'b0; run(5);

      // R5 / R6 toggle on overflow and priority
      cur_req = "R6";
      wr_cmp(per - 1);
      wr_cfg(2'b01, 2'b11, 1, 0);
      run(4 * per);
      cur_req = "R5";
      wr_cfg(2'b01, 2'b01, 1, 0);
      wr_cmp(3);
      run(3 * per);

      // R7 PWM with max duty
      cur_req = "R7";
      wr_cmp(6);
      wr_cfg(2'b01, 2'b10, 1, 0);
      run(2 * per);
      wait_cnt(2);
      wr_cfg(2'b01, 2'b10, 1, 1);
      run(per);
      wait_cnt(0); run(1);
      for (int k = 0; k < per; k++) begin
         chk(pin_out == 1, "R7", "full duty", pin_out, 1);
         cyc();
      end
      wait_cnt(3);
      wr_cfg(2'b01, 2'b10, 1, 0);
      run(3 * per);
      wr_cfg(2'b01, 2'b11, 1, 1);
      run(3 * per);
      wr_cfg(2'b01, 2'b11, 1, 0);
      run(2 * per);

      // R9 buffered compare
      cur_req = "R9";
      wr_cfg(2'b10, 2'b10, 1, 0);
      run(per);
      wait_cnt(3);
      wr_cmp(11);
      run(3 * per);
      wait_cnt(per - 1);
      cmp_wdata = W'(4); cmp_we = 1'b1; cyc(); cmp_we = 1'b0;
      run(3 * per);
      per = 12;
      wr_cfg(2'b11, 2'b01, 0, 0);
      wr_cmp(7);
      run(4 * per);

      // R8 clear racing a match
      cur_req = "R8";
      wait_cnt(7);
      flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
      run(2);
      chk(evt_flag == 1, "R8", "set beats clear", evt_flag, 1);
      clr_flag(); run(2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule